// File: doc/BRIEF.md
# Duplex Mirrored Memory Manager

This block connects one processor port to a bank of word-addressed memory modules. Each module holds 4096 words. A stored word is 28 bits: 26 data bits split into two 13-bit syllables, plus one parity bit for each syllable. The block builds the parity on writes and checks it on reads. It decodes the processor address to the module or modules involved, issues the request, and waits for every module it addressed to acknowledge. Only then does it report completion.

A runtime mode bit chooses between two ways of using the bank. In simplex mode every module is addressed independently, so eight modules give 32K words. In duplex mode modules 2k and 2k+1 form a mirrored pair. Every write goes to both modules, and every read fetches both copies. The parity result decides which copy is returned and whether to raise a correctable or an uncorrectable flag. Duplex mode halves the capacity to 16K words. The mode may only change while no transaction is in flight.

Top module: `duplex_mem_mgr`

## Requirements
- R1: After reset, `cpuReady` is 1, `cpuDone` is 0, `memReq` is all zero and `duplexOn` is 0 (simplex).
- R2: In simplex mode, `cpuAddr[14:12]` selects the module and `cpuAddr[11:0]` selects the word (`memAddr`). Exactly the one selected bit of `memReq` is raised while the transaction is outstanding.
- R3: A write presents the stored word on `memWdata` in this layout: bits 25:0 are the data, bit 26 is the XOR of data bits 12:0, and bit 27 is the XOR of data bits 25:13. A syllable is clean when its parity bit equals the XOR of its 13 data bits.
- R4: In simplex mode, a read whose word has a parity error returns the 26 data bits exactly as stored and raises `cpuUncorr`. `cpuCorr` stays 0.
- R5: In duplex mode, `cpuAddr[13:12]` selects pair k and `cpuAddr[14]` is ignored. Both `memReq[2k]` and `memReq[2k+1]` are raised.
- R6: A duplex write stores the word in both modules of the pair. `cpuDone` does not rise while any addressed module has yet to acknowledge.
- R7: A duplex read whose copy from module 2k (copy A) is clean returns copy A with both flags at 0, whatever copy B holds.
- R8: A duplex read with copy A bad and copy B clean returns copy B and raises `cpuCorr` only.
- R9: A duplex read with both copies bad returns copy A's data and raises `cpuUncorr` only.
- R10: A `modeSet` pulse loads `modeVal` into `duplexOn` only while `cpuReady` is 1. A pulse during an outstanding transaction has no effect.
- R11: `cpuReady` is 0 from the cycle after a request is accepted until `cpuDone`. `cpuDone` is a single-cycle pulse, and `cpuReady` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSet | input | 1 | Strobe to load a new mode |
| modeVal | input | 1 | Mode to load: 1 duplex, 0 simplex |
| duplexOn | output | 1 | Current mode |
| cpuReq | input | 1 | Processor request, taken when ready |
| cpuWe | input | 1 | 1 write, 0 read |
| cpuAddr | input | 15 | Processor word address |
| cpuWdata | input | 26 | Write data |
| cpuReady | output | 1 | Idle, able to accept a request |
| cpuDone | output | 1 | Transaction complete (one cycle) |
| cpuRdata | output | 26 | Read data, valid with cpuDone |
| cpuCorr | output | 1 | Read served from the mirror copy |
| cpuUncorr | output | 1 | Read data failed parity |
| memReq | output | 8 | Per-module request, held until acknowledged |
| memWe | output | 1 | Shared write enable |
| memAddr | output | 12 | Shared word address |
| memWdata | output | 28 | Shared word with parity |
| memAck | input | 8 | Per-module acknowledge, one cycle |
| memRdata | input | 224 | Per-module read word, 28 bits each, valid with its ack |

## Verification
The bench builds the block with its default eight modules, so every simplex module index and all four duplex pairs can be reached. Its memory model gives each module a different acknowledge latency. Within a pair, the odd module therefore always answers after the even one, which tests the wait-for-both rule on writes and reads. The four parity cases of a pair are each set up by flipping a stored data bit in one or both copies.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  localparam int SYL_W  = 13;
  localparam int DATA_W = 2 * SYL_W;
  localparam int CODE_W = DATA_W + 2;

  typedef struct packed {
    logic accept;
    logic done;
  } ctlStrobes_t;

  function automatic logic [CODE_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    return {^d[DATA_W-1:SYL_W], ^d[SYL_W-1:0], d};
  endfunction

  function automatic logic wordClean(input logic [CODE_W-1:0] w);
    return (w[DATA_W] == ^w[SYL_W-1:0]) && (w[DATA_W+1] == ^w[DATA_W-1:SYL_W]);
  endfunction
endpackage

// File: rtl/dmm_ctrl.sv
module dmm_ctrl
  import dmm_pkg::*;
#(
  parameter int NUM_MOD = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               modeSet,
  input  logic               modeVal,
  input  logic [NUM_MOD-1:0] reqMask,
  input  logic [NUM_MOD-1:0] memAck,
  output logic [NUM_MOD-1:0] pending,
  output logic [NUM_MOD-1:0] captureMask,
  output logic               duplexOn,
  output logic               cpuReady,
  output ctlStrobes_t        strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_t;
  state_t state;
  logic [NUM_MOD-1:0] remaining;

  assign remaining   = pending & ~memAck;
  assign captureMask = pending & memAck;
  assign cpuReady    = (state == ST_IDLE);
  assign strobes.accept = (state == ST_IDLE) && cpuReq && !modeSet;
  assign strobes.done   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pending  <= '0;
      duplexOn <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (modeSet) begin
            duplexOn <= modeVal;
          end else if (cpuReq) begin
            pending <= reqMask;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          pending <= remaining;
          if (remaining == '0) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmm_datapath.sv
module dmm_datapath
  import dmm_pkg::*;
#(
  parameter int NUM_MOD   = 8,
  parameter int WORD_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               strobes,
  input  logic [NUM_MOD-1:0]        captureMask,
  input  logic                      duplexOn,
  input  logic                      cpuWe,
  input  logic [WORD_BITS+$clog2(NUM_MOD)-1:0] cpuAddr,
  input  logic [DATA_W-1:0]         cpuWdata,
  input  logic [NUM_MOD*CODE_W-1:0] memRdata,
  output logic [NUM_MOD-1:0]        reqMask,
  output logic                      memWe,
  output logic [WORD_BITS-1:0]      memAddr,
  output logic [CODE_W-1:0]         memWdata,
  output logic                      cpuDone,
  output logic [DATA_W-1:0]         cpuRdata,
  output logic                      cpuCorr,
  output logic                      cpuUncorr
);
  localparam int MOD_BITS  = $clog2(NUM_MOD);
  localparam int PAIR_BITS = MOD_BITS - 1;

  logic [MOD_BITS-1:0]  modIdx;
  logic [PAIR_BITS-1:0] pairIdx;
  logic [MOD_BITS-1:0]  idxA, idxB;
  logic [CODE_W-1:0]    capt [NUM_MOD];
  logic [CODE_W-1:0]    wordA, wordB;
  logic                 cleanA, cleanB, dupLat;

  assign modIdx  = cpuAddr[WORD_BITS +: MOD_BITS];
  assign pairIdx = cpuAddr[WORD_BITS +: PAIR_BITS];

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    localparam logic [MOD_BITS-1:0] IDX = MOD_BITS'(i);
    assign reqMask[i] = duplexOn ? (IDX[MOD_BITS-1:1] == pairIdx) : (IDX == modIdx);
    always_ff @(posedge clk) begin
      if (!rstN) capt[i] <= '0;
      else if (captureMask[i]) capt[i] <= memRdata[i*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
      idxA     <= '0;
      idxB     <= '0;
      dupLat   <= 1'b0;
    end else if (strobes.accept) begin
      memWe    <= cpuWe;
      memAddr  <= cpuAddr[WORD_BITS-1:0];
      memWdata <= encodeWord(cpuWdata);
      idxA     <= duplexOn ? {pairIdx, 1'b0} : modIdx;
      idxB     <= {pairIdx, 1'b1};
      dupLat   <= duplexOn;
    end
  end

  assign wordA  = capt[idxA];
  assign wordB  = capt[idxB];
  assign cleanA = wordClean(wordA);
  assign cleanB = wordClean(wordB);

  always_comb begin
    cpuDone   = strobes.done;
    cpuRdata  = '0;
    cpuCorr   = 1'b0;
    cpuUncorr = 1'b0;
    if (strobes.done && !memWe) begin
      cpuRdata = wordA[DATA_W-1:0];
      if (!cleanA) begin
        if (dupLat && cleanB) begin
          cpuRdata = wordB[DATA_W-1:0];
          cpuCorr  = 1'b1;
        end else begin
          cpuUncorr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duplex_mem_mgr.sv
module duplex_mem_mgr
  import dmm_pkg::*;
#(
  parameter int NUM_MOD   = 8,
  parameter int WORD_BITS = 12,
  localparam int ADDR_W   = WORD_BITS + $clog2(NUM_MOD)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      modeSet,
  input  logic                      modeVal,
  output logic                      duplexOn,
  input  logic                      cpuReq,
  input  logic                      cpuWe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [DATA_W-1:0]         cpuWdata,
  output logic                      cpuReady,
  output logic                      cpuDone,
  output logic [DATA_W-1:0]         cpuRdata,
  output logic                      cpuCorr,
  output logic                      cpuUncorr,
  output logic [NUM_MOD-1:0]        memReq,
  output logic                      memWe,
  output logic [WORD_BITS-1:0]      memAddr,
  output logic [CODE_W-1:0]         memWdata,
  input  logic [NUM_MOD-1:0]        memAck,
  input  logic [NUM_MOD*CODE_W-1:0] memRdata
);
  ctlStrobes_t        strobes;
  logic [NUM_MOD-1:0] reqMask, captureMask;

  dmm_ctrl #(.NUM_MOD(NUM_MOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .modeSet(modeSet), .modeVal(modeVal),
    .reqMask(reqMask), .memAck(memAck), .pending(memReq), .captureMask(captureMask),
    .duplexOn(duplexOn), .cpuReady(cpuReady), .strobes(strobes)
  );

  dmm_datapath #(.NUM_MOD(NUM_MOD), .WORD_BITS(WORD_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .captureMask(captureMask),
    .duplexOn(duplexOn), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .reqMask(reqMask), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .cpuCorr(cpuCorr), .cpuUncorr(cpuUncorr)
  );
endmodule

// File: rtl/dmm_checker.sv
module dmm_checker #(
  parameter int NUM_MOD = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               duplexOn,
  input logic               cpuReady,
  input logic               cpuDone,
  input logic               cpuCorr,
  input logic               cpuUncorr,
  input logic [NUM_MOD-1:0] memReq
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (memReq == '0)); // R1
  AST_SIMPLEX_ONE_MODULE: assert property (@(posedge clk) disable iff (!rstN)
    !duplexOn |-> $onehot0(memReq)); // R2
  AST_DUPLEX_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    duplexOn |-> ($countones(memReq) <= 2)); // R5
  AST_DONE_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (memReq == '0)); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuCorr && cpuUncorr)); // R8
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuCorr || cpuUncorr) |-> cpuDone); // R9
  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReady |=> $stable(duplexOn)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> (!cpuDone && cpuReady)); // R11
endmodule

bind duplex_mem_mgr dmm_checker #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk(clk), .rstN(rstN), .duplexOn(duplexOn), .cpuReady(cpuReady), .cpuDone(cpuDone),
  .cpuCorr(cpuCorr), .cpuUncorr(cpuUncorr), .memReq(memReq)
);

// File: tb/duplex_mem_mgr_bench.sv
module duplex_mem_mgr_bench;
  localparam int NM = 8;
  localparam int CW = 28;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeSet = 0, modeVal = 0, cpuReq = 0, cpuWe = 0;
  logic [14:0] cpuAddr = '0;
  logic [25:0] cpuWdata = '0;
  logic duplexOn, cpuReady, cpuDone, cpuCorr, cpuUncorr, memWe;
  logic [25:0] cpuRdata;
  logic [NM-1:0] memReq, memAck;
  logic [11:0] memAddr;
  logic [CW-1:0] memWdata;
  logic [NM*CW-1:0] memRdata;

  int nChecks = 0, nFail = 0;
  logic [CW-1:0] store [int];

  always #2.5 clk = ~clk;

  duplex_mem_mgr u_duplex_mem_mgr (
    .clk(clk), .rstN(rstN), .modeSet(modeSet), .modeVal(modeVal), .duplexOn(duplexOn),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuDone(cpuDone), .cpuRdata(cpuRdata), .cpuCorr(cpuCorr),
    .cpuUncorr(cpuUncorr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // Module model: module i acknowledges i+2 cycles after it sees a request.
  for (genvar i = 0; i < NM; i++) begin : g_model
    logic busy = 1'b0, ack = 1'b0;
    int cnt = 0;
    logic [CW-1:0] rd = '0;
    assign memAck[i] = ack;
    assign memRdata[i*CW +: CW] = rd;
    always @(posedge clk) begin
      if (ack) begin
        ack <= 1'b0; busy <= 1'b0;
      end else if (busy) begin
        if (cnt <= 1) ack <= 1'b1;
        cnt <= cnt - 1;
      end else if (memReq[i]) begin
        busy <= 1'b1; cnt <= i + 2;
        if (memWe) store[i*4096 + int'(memAddr)] = memWdata;
        else rd <= store.exists(i*4096 + int'(memAddr)) ? store[i*4096 + int'(memAddr)] : '0;
      end
    end
  end

  function automatic logic [CW-1:0] enc(input logic [25:0] d);
    return {^d[25:13], ^d[12:0], d};
  endfunction

  function automatic logic [CW-1:0] peek(input int m, input int a);
    return store.exists(m*4096 + a) ? store[m*4096 + a] : '0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic corrupt(input int m, input int a);
    store[m*4096 + a] = peek(m, a) ^ 28'h8;
  endtask

  task automatic setMode(input logic v);
    @(negedge clk); modeSet = 1; modeVal = v;
    @(negedge clk); modeSet = 0;
  endtask

  // One transaction; expMask checked on first cycle after accept.
  task automatic doOp(input logic we, input logic [14:0] a, input logic [25:0] d,
                      input logic [NM-1:0] expMask, input string req, input bit modePulse,
                      output logic [25:0] rd, output logic corr, output logic unc);
    int n = 0;
    @(negedge clk); cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge clk); cpuReq = 0;
    check(memReq == expMask, req, 32'(memReq), 32'(expMask));
    check(!cpuReady, "R11", 32'(cpuReady), 0);
    if (modePulse) begin modeSet = 1; modeVal = ~duplexOn; end
    while (!cpuDone && n < 100) begin
      @(negedge clk); modeSet = 0; n++;
      if (memReq != 0 && cpuDone) check(0, "R6", 32'(memReq), 0);
    end
    check(cpuDone, "R11 done", 32'(cpuDone), 1);
    rd = cpuRdata; corr = cpuCorr; unc = cpuUncorr;
    @(negedge clk);
    check(!cpuDone && cpuReady, "R11 pulse", {cpuDone, cpuReady}, 32'b01);
  endtask

  task automatic t_reset();
    check(cpuReady && !cpuDone && memReq == 0 && !duplexOn, "R1",
          {cpuReady, cpuDone, duplexOn, memReq}, {3'b100, 8'h0});
  endtask

  task automatic t_simplex();
    logic [25:0] rd; logic c, u;
    doOp(1, {3'd5, 12'h123}, 26'h2A5_1C3F, 8'b0010_0000, "R2", 0, rd, c, u);
    check(peek(5, 'h123) == enc(26'h2A5_1C3F), "R3", peek(5, 'h123), enc(26'h2A5_1C3F));
    check(!store.exists(4*4096 + 'h123), "R2 other module", 0, 0);
    doOp(0, {3'd5, 12'h123}, 0, 8'b0010_0000, "R2", 0, rd, c, u);
    check(rd == 26'h2A5_1C3F && !c && !u, "R2 read", {rd, c, u}, {26'h2A5_1C3F, 2'b00});
  endtask

  task automatic t_simplexErr();
    logic [25:0] rd; logic c, u;
    doOp(1, {3'd1, 12'h010}, 26'h155_5555, 8'b0000_0010, "R2", 0, rd, c, u);
    corrupt(1, 'h010);
    doOp(0, {3'd1, 12'h010}, 0, 8'b0000_0010, "R2", 0, rd, c, u);
    check(rd == (26'h155_5555 ^ 26'h8) && !c && u, "R4", {rd, c, u}, {26'h155_5555 ^ 26'h8, 2'b01});
  endtask

  task automatic t_modeBusy();
    logic [25:0] rd; logic c, u;
    doOp(0, {3'd7, 12'h001}, 0, 8'b1000_0000, "R2", 1, rd, c, u);
    check(!duplexOn, "R10 busy", 32'(duplexOn), 0);
    setMode(1);
    check(duplexOn, "R10 idle", 32'(duplexOn), 1);
  endtask

  task automatic t_duplex();
    logic [25:0] rd; logic c, u;
    doOp(1, {1'b0, 2'd1, 12'h0AB}, 26'h0F0_F0F0, 8'b0000_1100, "R5", 0, rd, c, u);
    check(peek(2, 'h0AB) == enc(26'h0F0_F0F0) && peek(3, 'h0AB) == enc(26'h0F0_F0F0),
          "R6", peek(3, 'h0AB), enc(26'h0F0_F0F0));
    doOp(0, {1'b1, 2'd1, 12'h0AB}, 0, 8'b0000_1100, "R5 alias", 0, rd, c, u);
    check(rd == 26'h0F0_F0F0 && !c && !u, "R7", {rd, c, u}, {26'h0F0_F0F0, 2'b00});
    corrupt(3, 'h0AB);
    doOp(0, {1'b0, 2'd1, 12'h0AB}, 0, 8'b0000_1100, "R5", 0, rd, c, u);
    check(rd == 26'h0F0_F0F0 && !c && !u, "R7 B bad", {rd, c, u}, {26'h0F0_F0F0, 2'b00});
    corrupt(3, 'h0AB); corrupt(2, 'h0AB);
    doOp(0, {1'b0, 2'd1, 12'h0AB}, 0, 8'b0000_1100, "R5", 0, rd, c, u);
    check(rd == 26'h0F0_F0F0 && c && !u, "R8", {rd, c, u}, {26'h0F0_F0F0, 2'b10});
    corrupt(3, 'h0AB); store[3*4096 + 'h0AB] = peek(3, 'h0AB) ^ 28'h4000;
    doOp(0, {1'b0, 2'd1, 12'h0AB}, 0, 8'b0000_1100, "R5", 0, rd, c, u);
    check(rd == (26'h0F0_F0F0 ^ 26'h8) && !c && u, "R9", {rd, c, u}, {26'h0F0_F0F0 ^ 26'h8, 2'b01});
  endtask

  task automatic t_backSimplex();
    logic [25:0] rd; logic c, u;
    setMode(0);
    check(!duplexOn, "R10 back", 32'(duplexOn), 0);
    doOp(1, {3'd6, 12'h200}, 26'h3FF_FFFF, 8'b0100_0000, "R2", 0, rd, c, u);
    check(!store.exists(7*4096 + 'h200), "R2 no mirror", 0, 0);
  endtask

  initial begin
    #500us;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_simplex();
    t_simplexErr();
    t_modeBusy();
    t_duplex();
    t_backSimplex();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule